// File: doc/BRIEF.md
# Stored Header Field Rewriter

This block keeps a table of 32 packet header images, each sixteen 32-bit words wide. A sender can store a header image in a slot, then emit that image again for later packets with a few bit fields changed on the way out. Each change is given as a packed 32-bit update word. The word names one header word and a bit field within it, and carries the new value for that field. The image held in the slot is never changed by an update, so one stored image can serve many packets.

A request carries a control word. The control word holds a 3-bit mode and a 5-bit slot number, together with a word count that says how much of the header to emit. The count can be smaller than the stored image, so a long stored header can serve a shorter packet. The chosen header is streamed out one word per cycle, starting with word 0.

A separate capture port can write a header image into any slot at any time. If that port targets the slot that an accepted request uses in the same cycle, the block raises a collision flag.

Top module: `hdr_patch_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `out_valid` is 0, `rq_ready` is 1 and `err_collide` is 0.
- R2: An update word is laid out as follows: enable in bit 31, field start in bits 28:24, field length in bits 23:20, header word index in bits 19:16, data in bits 15:0. It replaces bits start to start+length-1 of the selected header word with the low `length` bits of the data. A length of 0 changes nothing.
- R3: An update word whose enable bit is 0 has no effect on the emitted header.
- R4: A field that would extend past bit 31 is cut off at bit 31. The bits beyond the word are dropped, and no other header word is touched.
- R5: Mode 2 applies update word 0 only, mode 3 applies words 0 and 1, and mode 4 applies words 0, 1 and 2. Update word k sits in bits 32k+31:32k of `rq_upd`. The updates are applied in index order, so when fields overlap, a later update wins. Update words beyond the count for the mode are ignored.
- R6: Applying updates never changes the image held in a slot. A later request that reads the slot sees the image as it was captured.
- R7: In `rq_ctrl`, bits 15:13 hold the mode and bits 12:8 hold the slot; the other bits are ignored. Mode 1 stores `rq_hdr` into the slot and emits `rq_hdr` unchanged. Modes 0, 5, 6 and 7 emit `rq_hdr` unchanged and store nothing.
- R8: When `cap_valid` is high, `cap_hdr` is written into slot `cap_slot` at the clock edge. No output is produced. Later requests in modes 2 to 4 read the written image.
- R9: A request is accepted on a clock edge where `rq_valid` and `rq_ready` are both 1. From the next cycle, header words 0 to L-1 appear one per cycle on `out_data`. Word j is bits 32j+31:32j of the header, and `out_idx` equals j. `out_last` marks the final word, and `rq_ready` stays low while words remain. L is `rq_len`, limited to 16. A length of 0 emits nothing.
- R10: Suppose `cap_valid` is high, a request in mode 1 to 4 is accepted on the same edge, and both name the same slot. Then `err_collide` is 1 for exactly the next cycle. An applying request uses the slot image from before the capture. For mode 1, the slot ends up holding `rq_hdr`. No other combination raises the flag.
- R11: All 32 slots, 0 to 31, can be captured and read independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_valid | input | 1 | Write `cap_hdr` into a slot |
| cap_slot | input | 5 | Slot written by the capture port |
| cap_hdr | input | 512 | Header image for the capture port, word j in bits 32j+31:32j |
| rq_valid | input | 1 | Request present |
| rq_ready | output | 1 | Block can accept a request |
| rq_ctrl | input | 16 | Control word: mode in 15:13, slot in 12:8 |
| rq_upd | input | 96 | Three packed update words |
| rq_len | input | 5 | Number of header words to emit |
| rq_hdr | input | 512 | Header for pass-through and store modes |
| out_valid | output | 1 | `out_data` holds a header word |
| out_data | output | 32 | Emitted header word |
| out_idx | output | 4 | Index of the emitted word |
| out_last | output | 1 | Final word of the header |
| err_collide | output | 1 | Capture and request hit the same slot in the previous cycle |

## Verification
The bench targets overlapping updates in modes 3 and 4. A rewriter that applied the updates in reverse order, or that applied more updates than the mode asks for, would emit the wrong value in the shared bits. Fields placed near bit 31 check the clipping: a design without it would leak bits into the next header word or wrap them into low bits. The bench also re-reads a slot after updates to catch write-back into storage. It drives same-cycle capture and request collisions in apply, store and pass-through modes to check both the flag and which image wins. It uses lengths of 0, 1 and 20 to check the clamp and the empty request.

// File: rtl/hpe_pkg.sv
package hpe_pkg;

   localparam int WORD_W = 32;
   localparam int SLOT_W = 5;
   localparam int MODE_W = 3;

   // bit positions of the update word (decoded by the rewriter)
   typedef struct packed {
      logic       en;
      logic [1:0] rsvd;
      logic [4:0] start;
      logic [3:0] flen;
      logic [3:0] widx;
      logic [15:0] val;
   } upd_t;

   typedef enum logic [MODE_W-1:0] {
      MODE_PASS  = 3'd0,
      MODE_STORE = 3'd1,
      MODE_UPD1  = 3'd2,
      MODE_UPD2  = 3'd3,
      MODE_UPD3  = 3'd4
   } mode_e;

   // field mask; bits shifted beyond bit 31 fall away, which clips the field
   function automatic logic [WORD_W-1:0] fld_mask(input logic [4:0] s, input logic [3:0] l);
      return ((32'd1 << l) - 32'd1) << s;
   endfunction

endpackage

// File: rtl/hpe_slot_store.sv
module hpe_slot_store #(
   parameter int SLOTS = 32,
   parameter int HB    = 512
) (
   input  logic          clk,
   input  logic          a_we,
   input  logic [4:0]    a_slot,
   input  logic [HB-1:0] a_data,
   input  logic          b_we,
   input  logic [4:0]    b_slot,
   input  logic [HB-1:0] b_data,
   input  logic [4:0]    rd_slot,
   output logic [HB-1:0] rd_data
);

   logic [HB-1:0] mem [SLOTS];

   // port b has priority over port a on the same slot
   always_ff @(posedge clk) begin
      for (int i = 0; i < SLOTS; i++) begin
         if (b_we && b_slot == 5'(i))
            mem[i] <= b_data;
         else if (a_we && a_slot == 5'(i))
            mem[i] <= a_data;
      end
   end

   assign rd_data = mem[rd_slot];

endmodule

// File: rtl/hpe_patch_stage.sv
module hpe_patch_stage
   import hpe_pkg::*;
#(
   parameter int HDR_WORDS = 16,
   localparam int HB = HDR_WORDS * WORD_W
) (
   input  logic          act_i,
   input  upd_t          upd_i,
   input  logic [HB-1:0] hdr_i,
   output logic [HB-1:0] hdr_o
);

   logic [WORD_W-1:0] mask;
   logic [WORD_W-1:0] shifted;
   logic              unused_rsvd;

   assign mask        = fld_mask(upd_i.start, upd_i.flen);
   assign shifted     = WORD_W'(upd_i.val) << upd_i.start;
   assign unused_rsvd = ^upd_i.rsvd;

   for (genvar j = 0; j < HDR_WORDS; j++) begin : g_word
      logic hit;
      assign hit = act_i && upd_i.en && (upd_i.widx == 4'(j));
      assign hdr_o[j*WORD_W +: WORD_W] = hit
         ? ((hdr_i[j*WORD_W +: WORD_W] & ~mask) | (shifted & mask))
         : hdr_i[j*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/hpe_out_stream.sv
module hpe_out_stream
   import hpe_pkg::*;
#(
   parameter int HDR_WORDS = 16,
   localparam int HB    = HDR_WORDS * WORD_W,
   localparam int IDX_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1,
   localparam int LEN_W = $clog2(HDR_WORDS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [HB-1:0]     load_hdr,
   input  logic [LEN_W-1:0]  load_len,
   output logic              idle,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic [IDX_W-1:0]  out_idx,
   output logic              out_last
);

   logic [HB-1:0]    hbuf;
   logic [IDX_W-1:0] pos;
   logic [LEN_W-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
         rem <= '0;
      end else if (load) begin
         pos <= '0;
         rem <= load_len;
      end else if (rem != '0) begin
         pos <= pos + 1'b1;
         rem <= rem - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (load) hbuf <= load_hdr;
   end

   assign idle      = (rem == '0);
   assign out_valid = (rem != '0);
   assign out_last  = (rem == LEN_W'(1));
   assign out_idx   = pos;
   assign out_data  = hbuf[int'(pos)*WORD_W +: WORD_W];

endmodule

// File: rtl/hdr_patch_engine.sv
module hdr_patch_engine
   import hpe_pkg::*;
#(
   parameter int SLOTS     = 32,
   parameter int HDR_WORDS = 16,
   parameter int MAX_UPD   = 3,
   localparam int HB    = HDR_WORDS * WORD_W,
   localparam int IDX_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1,
   localparam int LEN_W = $clog2(HDR_WORDS + 1)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap_valid,
   input  logic [SLOT_W-1:0]         cap_slot,
   input  logic [HB-1:0]             cap_hdr,
   input  logic                      rq_valid,
   output logic                      rq_ready,
   input  logic [15:0]               rq_ctrl,
   input  logic [MAX_UPD*WORD_W-1:0] rq_upd,
   input  logic [LEN_W-1:0]          rq_len,
   input  logic [HB-1:0]             rq_hdr,
   output logic                      out_valid,
   output logic [WORD_W-1:0]         out_data,
   output logic [IDX_W-1:0]          out_idx,
   output logic                      out_last,
   output logic                      err_collide
);

   // elaboration checks
   if (SLOTS < 1 || SLOTS > 32) begin : g_bad_slots
      $error("SLOTS must lie in 1..32");
   end
   if (HDR_WORDS < 1 || HDR_WORDS > 16) begin : g_bad_words
      $error("HDR_WORDS must lie in 1..16");
   end
   if (MAX_UPD < 1 || MAX_UPD > 3) begin : g_bad_upd
      $error("MAX_UPD must lie in 1..3");
   end

   logic [MODE_W-1:0] mode;
   logic [SLOT_W-1:0] slot;
   logic              rq_fire;
   logic              is_apply;
   logic              is_store;
   logic              idle;
   logic              err_q;
   logic              unused_ctrl;
   logic [HB-1:0]     slot_img;
   logic [HB-1:0]     src_hdr;
   logic [LEN_W-1:0]  len_eff;
   logic [MAX_UPD-1:0] act;
   logic [HB-1:0]     chain [MAX_UPD+1];

   assign mode        = rq_ctrl[15:13];
   assign slot        = rq_ctrl[12:8];
   assign unused_ctrl = ^rq_ctrl[7:0];

   assign rq_ready = idle;
   assign rq_fire  = rq_valid && idle;
   assign is_store = (mode == MODE_STORE);
   assign is_apply = (mode >= MODE_UPD1) && (mode <= MODE_W'(1 + MAX_UPD));
   assign len_eff  = (rq_len > LEN_W'(HDR_WORDS)) ? LEN_W'(HDR_WORDS) : rq_len;

   hpe_slot_store #(
      .SLOTS (SLOTS),
      .HB    (HB)
   ) u_store (
      .clk     (clk),
      .a_we    (cap_valid),
      .a_slot  (cap_slot),
      .a_data  (cap_hdr),
      .b_we    (rq_fire && is_store),
      .b_slot  (slot),
      .b_data  (rq_hdr),
      .rd_slot (slot),
      .rd_data (slot_img)
   );

   assign src_hdr  = is_apply ? slot_img : rq_hdr;
   assign chain[0] = src_hdr;

   for (genvar k = 0; k < MAX_UPD; k++) begin : g_stage
      assign act[k] = is_apply && (mode >= MODE_W'(2 + k));
      hpe_patch_stage #(
         .HDR_WORDS (HDR_WORDS)
      ) u_stage (
         .act_i (act[k]),
         .upd_i (upd_t'(rq_upd[k*WORD_W +: WORD_W])),
         .hdr_i (chain[k]),
         .hdr_o (chain[k+1])
      );
   end

   hpe_out_stream #(
      .HDR_WORDS (HDR_WORDS)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rq_fire),
      .load_hdr  (chain[MAX_UPD]),
      .load_len  (len_eff),
      .idle      (idle),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_idx   (out_idx),
      .out_last  (out_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else
         err_q <= cap_valid && rq_fire && (is_store || is_apply) && (cap_slot == slot);
   end

   assign err_collide = err_q;

endmodule

// File: rtl/hpe_checker.sv
module hpe_checker #(
   parameter int HDR_WORDS = 16,
   localparam int IDX_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1,
   localparam int LEN_W = $clog2(HDR_WORDS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cap_valid,
   input logic [4:0]       cap_slot,
   input logic             rq_valid,
   input logic             rq_ready,
   input logic [15:0]      rq_ctrl,
   input logic [LEN_W-1:0] rq_len,
   input logic             out_valid,
   input logic [IDX_W-1:0] out_idx,
   input logic             out_last,
   input logic             err_collide
);

   logic taken;
   logic clash;
   logic unused_ctrl;

   assign taken       = rq_valid && rq_ready;
   assign clash       = cap_valid && taken && (rq_ctrl[15:13] >= 3'd1) &&
                        (rq_ctrl[15:13] <= 3'd4) && (cap_slot == rq_ctrl[12:8]);
   assign unused_ctrl = ^rq_ctrl[7:0];

   // R9
   first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && rq_len != '0) |=> (out_valid && out_idx == '0));

   // R9
   empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (taken && rq_len == '0) |=> !out_valid);

   // R9
   word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> (out_valid && out_idx == IDX_W'($past(out_idx) + 1'b1)));

   // R9
   last_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |=> !out_valid);

   // R9
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !rq_ready);

   // R10
   collide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clash |=> err_collide);

   // R10
   collide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clash |=> !err_collide);

endmodule

bind hdr_patch_engine hpe_checker #(
   .HDR_WORDS (HDR_WORDS)
) u_hpe_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cap_valid   (cap_valid),
   .cap_slot    (cap_slot),
   .rq_valid    (rq_valid),
   .rq_ready    (rq_ready),
   .rq_ctrl     (rq_ctrl),
   .rq_len      (rq_len),
   .out_valid   (out_valid),
   .out_idx     (out_idx),
   .out_last    (out_last),
   .err_collide (err_collide)
);

// File: tb/hdr_patch_engine_test.sv
`timescale 1ns/1ps
module hdr_patch_engine_test;

   localparam int HW = 16;
   localparam int HB = HW * 32;
   localparam int NS = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cap_valid = 1'b0;
   logic [4:0]    cap_slot = '0;
   logic [HB-1:0] cap_hdr = '0;
   logic          rq_valid = 1'b0;
   logic          rq_ready;
   logic [15:0]   rq_ctrl = '0;
   logic [95:0]   rq_upd = '0;
   logic [4:0]    rq_len = '0;
   logic [HB-1:0] rq_hdr = '0;
   logic          out_valid;
   logic [31:0]   out_data;
   logic [3:0]    out_idx;
   logic          out_last;
   logic          err_collide;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   hdr_patch_engine uut (
      .clk(clk), .rst_n(rst_n),
      .cap_valid(cap_valid), .cap_slot(cap_slot), .cap_hdr(cap_hdr),
      .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_ctrl(rq_ctrl),
      .rq_upd(rq_upd), .rq_len(rq_len), .rq_hdr(rq_hdr),
      .out_valid(out_valid), .out_data(out_data), .out_idx(out_idx),
      .out_last(out_last), .err_collide(err_collide)
   );

   // reference model state
   logic [HB-1:0] ref_slot [NS];
   logic [31:0]   q_data [$];
   int            q_idx [$];
   bit            err_exp = 0;

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   function automatic logic [HB-1:0] pat(input logic [7:0] seed);
      logic [HB-1:0] h;
      for (int j = 0; j < HW; j++)
         h[j*32 +: 32] = {seed, 8'(j), 8'(seed * 8'd3 + 8'(j)), 8'h5A ^ 8'(j)};
      return h;
   endfunction

   function automatic logic [31:0] mk(input bit en, input int s, input int l, input int w, input logic [15:0] d);
      return {en, 2'b00, 5'(s), 4'(l), 4'(w), d};
   endfunction

   // behavioural model, advanced on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         q_data.delete();
         q_idx.delete();
         err_exp = 0;
      end else begin
         bit            fire;
         int            m, s, n, L;
         logic [HB-1:0] h;
         fire = rq_valid && (q_data.size() == 0);
         if (q_data.size() != 0) begin
            void'(q_data.pop_front());
            void'(q_idx.pop_front());
         end
         m = int'(rq_ctrl[15:13]);
         s = int'(rq_ctrl[12:8]);
         err_exp = fire && cap_valid && m >= 1 && m <= 4 && int'(cap_slot) == s;
         if (fire) begin
            if (m >= 2 && m <= 4) begin
               h = ref_slot[s];
               n = m - 1;
            end else begin
               h = rq_hdr;
               n = 0;
            end
            for (int k = 0; k < n; k++) begin
               logic [31:0] u;
               u = rq_upd[k*32 +: 32];
               if (u[31]) begin
                  for (int b = 0; b < int'(u[23:20]); b++) begin
                     int p;
                     p = int'(u[28:24]) + b;
                     if (p < 32) h[int'(u[19:16])*32 + p] = u[b];
                  end
               end
            end
            L = (int'(rq_len) > HW) ? HW : int'(rq_len);
            for (int j = 0; j < L; j++) begin
               q_data.push_back(h[j*32 +: 32]);
               q_idx.push_back(j);
            end
         end
         if (cap_valid) ref_slot[cap_slot] = cap_hdr;
         if (fire && m == 1) ref_slot[s] = rq_hdr;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ev;
         ev = (q_data.size() != 0);
         check(out_valid === ev, "out_valid", 32'(out_valid), 32'(ev));
         check(rq_ready === !ev, "rq_ready", 32'(rq_ready), 32'(!ev));
         check(err_collide === err_exp, "err_collide", 32'(err_collide), 32'(err_exp));
         if (ev) begin
            check(out_data === q_data[0], "out_data", out_data, q_data[0]);
            check(out_idx === 4'(q_idx[0]), "out_idx", 32'(out_idx), 32'(q_idx[0]));
            check(out_last === (q_data.size() == 1), "out_last", 32'(out_last), 32'(q_data.size() == 1));
         end
      end
   end

   task automatic drive(input bit do_rq, input int m, input int s, input int len,
                        input logic [95:0] upd, input logic [HB-1:0] hdr,
                        input bit do_cap, input int cs, input logic [HB-1:0] ch);
      @(negedge clk);
      while (q_data.size() != 0) @(negedge clk);
      #1;
      rq_valid  = do_rq;
      rq_ctrl   = {3'(m), 5'(s), 8'hC3};
      rq_len    = 5'(len);
      rq_upd    = upd;
      rq_hdr    = hdr;
      cap_valid = do_cap;
      cap_slot  = 5'(cs);
      cap_hdr   = ch;
      @(negedge clk);
      #1;
      rq_valid  = 1'b0;
      cap_valid = 1'b0;
   endtask

   task automatic capture(input int cs, input logic [HB-1:0] ch);
      drive(0, 0, 0, 0, '0, '0, 1, cs, ch);
   endtask

   task automatic request(input int m, input int s, input int len, input logic [95:0] upd, input logic [HB-1:0] hdr);
      drive(1, m, s, len, upd, hdr, 0, 0, '0);
   endtask

   task automatic drain();
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NS; i++) ref_slot[i] = '0;
      // R1: reset state
      cur_req = "R1";
      repeat (3) @(negedge clk);
      check(out_valid === 1'b0, "reset out_valid", 32'(out_valid), 0);
      check(rq_ready === 1'b1, "reset rq_ready", 32'(rq_ready), 1);
      check(err_collide === 1'b0, "reset err_collide", 32'(err_collide), 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid === 1'b0, "post-reset out_valid", 32'(out_valid), 0);
      check(rq_ready === 1'b1, "post-reset rq_ready", 32'(rq_ready), 1);

      // R8 and R11: capture port, edge slots, read back
      cur_req = "R8";
      capture(0, pat(8'h01));
      capture(5, pat(8'h02));
      capture(31, pat(8'h03));
      request(2, 5, 16, '0, '0);
      cur_req = "R11";
      request(2, 31, 16, '0, '0);
      request(2, 0, 16, '0, '0);

      // R3: disabled update word
      cur_req = "R3";
      request(2, 5, 4, {64'h0, mk(0, 0, 15, 0, 16'hFFFF)}, '0);

      // R7: pass-through and store modes
      cur_req = "R7";
      request(0, 3, 4, {3{mk(1, 0, 15, 0, 16'h7FFF)}}, pat(8'h09));
      request(6, 3, 2, '0, pat(8'h0A));
      request(1, 7, 3, '0, pat(8'h0B));
      request(2, 7, 16, '0, '0);

      // R2: simple field and zero-length field
      cur_req = "R2";
      request(2, 7, 4, {64'h0, mk(1, 4, 8, 2, 16'h00AB)}, '0);
      request(2, 7, 4, {64'h0, mk(1, 3, 0, 1, 16'hFFFF)}, '0);

      // R4: clipping at bit 31
      cur_req = "R4";
      request(2, 7, 5, {64'h0, mk(1, 28, 8, 0, 16'h00FF)}, '0);
      request(2, 7, 5, {64'h0, mk(1, 31, 15, 3, 16'h0000)}, '0);

      // R5: ordering and per-mode update count
      cur_req = "R5";
      request(4, 7, 2, {mk(1, 8, 4, 0, 16'h000F), mk(1, 4, 8, 0, 16'h0055), mk(1, 0, 12, 0, 16'h0ABC)}, '0);
      request(3, 7, 2, {mk(1, 8, 4, 0, 16'h000F), mk(1, 4, 8, 0, 16'h0055), mk(1, 0, 12, 0, 16'h0ABC)}, '0);
      request(2, 7, 2, {mk(1, 0, 15, 0, 16'h1234), mk(1, 0, 15, 1, 16'h4321), mk(1, 16, 8, 0, 16'h00EE)}, '0);

      // R6: slot image untouched by the updates above
      cur_req = "R6";
      request(2, 7, 16, '0, '0);

      // R9: length clamp, empty and single-word requests
      cur_req = "R9";
      request(2, 0, 20, '0, '0);
      request(2, 0, 0, '0, '0);
      request(2, 31, 1, '0, '0);

      // R10: collisions
      cur_req = "R10";
      drive(1, 3, 5, 3, {32'h0, mk(1, 0, 8, 0, 16'h0011), mk(1, 0, 8, 1, 16'h0022)}, '0, 1, 5, pat(8'h20));
      request(2, 5, 16, '0, '0);
      drive(1, 2, 5, 2, '0, '0, 1, 6, pat(8'h21));
      drive(1, 1, 9, 2, '0, pat(8'h23), 1, 9, pat(8'h22));
      request(2, 9, 16, '0, '0);
      drive(1, 0, 6, 2, '0, pat(8'h24), 1, 6, pat(8'h25));
      request(2, 6, 4, '0, '0);

      drain();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule